// File: doc/BRIEF.md
# Asynchronous SRAM Host Controller

This block lets a clocked system read and write one external asynchronous static RAM of 8K words by 8 bits. The host presents an address, write data and a read/write select together with a valid strobe. The controller accepts the request when it is idle, runs one complete memory cycle, and raises a one-clock done pulse. For a read, the word fetched from the memory appears on the read-data output at that same time.

On the memory side the controller drives two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and the address. The bidirectional data pins are split into an outgoing word, an incoming word and a drive enable. The pad ring joins them.

Every cycle runs through the phases setup, strobe, hold and turnaround. Each phase length is a cycle count worked out at elaboration time from the clock period and the memory's nanosecond limits. The limits covered are access time, output-enable access, write pulse width, write cycle length, data setup and output release. The counts are chosen so that the memory's timing is met with no asynchronous logic.

Top module: `sram_host_ctrl`

## Requirements
- R1: While reset is low and in idle, the memory is deselected (mem_cs_n=1, mem_cs=0), mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, done=0, and req_ready=1.
- R2: A request is taken only on a clock edge where req_ready=1 and req_valid=1. A valid request held while the controller is busy (req_ready=0) has no effect on the memory.
- R3: A read asserts mem_oe_n=0 for exactly RD_STB cycles with mem_we_n=1 and mem_dq_oe=0. It returns on rdata the word the memory drives at the last strobe cycle.
- R4: A write asserts mem_we_n=0 for exactly WR_STB cycles with mem_oe_n=1, mem_dq_oe=1, mem_dout equal to the request's write data and mem_addr equal to its address. The memory holds that word afterwards.
- R5: Both chip selects are active for at least one cycle before a strobe falls and still active in the cycle after it rises. mem_addr does not change while the memory is selected. A strobe is never low while the memory is deselected.
- R6: mem_dq_oe is never high while mem_oe_n=0. After the output enable rises, the drivers stay off for at least 1+TA_CYC cycles.
- R7: done is high for exactly one clock, 2+STB negative clock edges after the accepting edge. rdata changes only in a cycle where done is high and otherwise holds the last read word, including across writes.
- R8: Phase counts are ceil(t/CLK_NS) with a floor of 1: RD_STB = max(ceil(20/CLK), ceil(10/CLK)), WR_STB = max(ceil(15/CLK), ceil(10/CLK), ceil(20/CLK)-2), TA_CYC = ceil(8/CLK). With a 20 ns clock each of these is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | High when a request can be taken (idle) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last word read |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 13 | Memory address |
| mem_dout | output | 8 | Data toward the memory |
| mem_din | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dout |

## Verification
Several properties are checked on every cycle:
- strobe and select ordering;
- write and output enables never low together;
- no driver enable during an output enable, and the turnaround gap after one;
- the minimum write pulse;
- a stable address while selected;
- the single-cycle done pulse, and rdata moving only with done.

Only the bench scenarios can show the following:
- that every one of the 8192 locations actually stores and returns its word;
- that the done latency matches the computed phase counts;
- that a request presented while busy leaves the memory unchanged;
- that rdata survives an intervening write.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the SRAM host controller.
// Assumes all timing limits are positive integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_TURN   = 3'd4
    } seq_state_e;

    // Round a nanosecond limit up to whole clocks, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: accepts a request in idle, latches it, and steps through
// setup, strobe, hold and turnaround using a down-counter for multi-cycle
// phases. Assumes the strobe and turnaround counts are at least one.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int RD_STB = 1,
    parameter int WR_STB = 1,
    parameter int TA_CYC = 1,
    parameter int CNT_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output seq_state_e        state,
    output logic              lat_we,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              rd_capture,
    output logic              done
);

    logic [CNT_W-1:0] cnt;
    logic             last_strobe;

    // Final cycle of the strobe phase.
    assign last_strobe = (state == ST_STROBE) && (cnt == '0);
    // Read data is taken on the final strobe cycle of a read only.
    assign rd_capture  = last_strobe && !lat_we;

    // State, phase counter, latched request and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_we    <= req_we;
                        lat_addr  <= req_addr;
                        lat_wdata <= req_wdata;
                        state     <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt   <= lat_we ? CNT_W'(WR_STB - 1) : CNT_W'(RD_STB - 1);
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (last_strobe) begin
                        done  <= 1'b1;
                        state <= ST_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    cnt   <= CNT_W'(TA_CYC - 1);
                    state <= ST_TURN;
                end
                ST_TURN: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_pin_decode.sv
`timescale 1ns/1ps
// Decodes memory pin levels from the sequencer state and the latched
// request. Selects span setup, strobe and hold; write data is driven
// for the whole selected window of a write.
module sram_pin_decode
    import sram_ctrl_pkg::*;
(
    input  seq_state_e state,
    input  logic       lat_we,
    output logic       sel,
    output logic       we_n,
    output logic       oe_n,
    output logic       dq_oe,
    output logic       ready
);

    // Pin levels as a pure function of phase and direction.
    always_comb begin
        sel   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        we_n  = !((state == ST_STROBE) && lat_we);
        oe_n  = !((state == ST_STROBE) && !lat_we);
        dq_oe = sel && lat_we;
        ready = (state == ST_IDLE);
    end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
// Read-data register: loads the memory's word when told to and holds it
// otherwise. Assumes the load strobe comes while the output enable is low.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Hold the last read word until the next read finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

endmodule

// File: rtl/sram_host_ctrl.sv
`timescale 1ns/1ps
// Synchronous host controller for an asynchronous 8-bit static RAM.
// Derives phase lengths from CLK_NS and the memory's nanosecond limits,
// then sequences selects, strobes and data drivers to meet them.
// Assumes mem_din is already synchronous enough to sample after the
// access time, i.e. the board delay is inside the limits given.
module sram_host_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int CLK_NS       = 20,
    parameter int T_ACCESS_NS  = 20,
    parameter int T_OE_NS      = 10,
    parameter int T_WPULSE_NS  = 15,
    parameter int T_WCYCLE_NS  = 20,
    parameter int T_DSETUP_NS  = 10,
    parameter int T_RELEASE_NS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dq_oe
);

    localparam int RD_STB = max2(ns_to_cycles(T_ACCESS_NS, CLK_NS),
                                 ns_to_cycles(T_OE_NS, CLK_NS));
    localparam int WR_STB = max2(max2(ns_to_cycles(T_WPULSE_NS, CLK_NS),
                                      ns_to_cycles(T_DSETUP_NS, CLK_NS)),
                                 ns_to_cycles(T_WCYCLE_NS, CLK_NS) - 2);
    localparam int TA_CYC = ns_to_cycles(T_RELEASE_NS, CLK_NS);
    localparam int MAX_C  = max2(max2(RD_STB, WR_STB), TA_CYC);
    localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    seq_state_e        state;
    logic              lat_we;
    logic              rd_capture;
    logic              sel;

    sram_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_STB(RD_STB),
        .WR_STB(WR_STB), .TA_CYC(TA_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .state(state),
        .lat_we(lat_we), .lat_addr(mem_addr), .lat_wdata(mem_dout),
        .rd_capture(rd_capture), .done(done)
    );

    sram_pin_decode u_pins (
        .state(state), .lat_we(lat_we), .sel(sel), .we_n(mem_we_n),
        .oe_n(mem_oe_n), .dq_oe(mem_dq_oe), .ready(req_ready)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .load(rd_capture),
        .din(mem_din), .dout(rdata)
    );

    // Both chip selects follow one internal select.
    assign mem_cs_n = !sel;
    assign mem_cs   = sel;

endmodule

// File: rtl/sram_host_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the controller: strobe/select ordering, bus
// contention, write pulse width, turnaround gap, done and rdata behaviour.
module sram_host_ctrl_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int WR_STB = 1,
    parameter int TA_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [DATA_W-1:0] rdata,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);

    logic [7:0] we_low_cnt;
    logic [7:0] since_oe;

    // Length of the current run of write-strobe-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_cnt <= '0;
        else if (!mem_we_n) we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1;
        else                we_low_cnt <= '0;
    end

    // Cycles since the output enable was last low (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)         since_oe <= 8'hFF;
        else if (!mem_oe_n) since_oe <= '0;
        else if (since_oe != 8'hFF) since_oe <= since_oe + 1'b1;
    end

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_accept_on_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_write_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_low_cnt) >= WR_STB));

    assert_strobe_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (!mem_cs_n && mem_cs));

    assert_select_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) || $fell(mem_oe_n)) |-> $past(!mem_cs_n && mem_cs));

    assert_select_trail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) || $rose(mem_oe_n)) |-> (!mem_cs_n && mem_cs));

    assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    assert_turnaround_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(since_oe) >= TA_CYC + 1));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_rdata_moves_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);

endmodule

bind sram_host_ctrl sram_host_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_STB(WR_STB), .TA_CYC(TA_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .rdata(rdata), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_host_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural asynchronous RAM model, full write and read sweep,
// busy-request rejection and read-data hold checks.
module sram_host_ctrl_tb;

    localparam int CLK_NS = 20;
    localparam int DEPTH  = 8192;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD = mx(cyc(20), cyc(10));
    localparam int E_WR = mx(mx(cyc(15), cyc(10)), cyc(20) - 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rdata;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [12:0] mem_addr;
    logic [7:0]  mem_dout, mem_din;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] model [DEPTH];

    always #(CLK_NS/2) clk = ~clk;

    sram_host_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dq_oe(mem_dq_oe)
    );

    // Memory drives its pins only when selected, reading, output enabled.
    assign mem_din = (!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n) ? model[mem_addr] : 8'h00;

    // Write completes on the rising write strobe while selected.
    always @(posedge mem_we_n) begin
        if (!mem_cs_n && mem_cs && mem_dq_oe) model[mem_addr] = mem_dout;
    end

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'((a * 37) ^ (a >> 5) ^ seed);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One host transaction with pin-level monitoring at negative edges.
    task automatic do_op(input bit we, input logic [12:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
        int lat, wlow, olow, bad_pins;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; wlow = 0; olow = 0; bad_pins = 0;
        while (!done && lat < 64) begin
            if (!mem_we_n) begin
                wlow++;
                if (!(mem_oe_n && mem_dq_oe && mem_dout == d && mem_addr == a)) bad_pins++;
            end
            if (!mem_oe_n) begin
                olow++;
                if (!(mem_we_n && !mem_dq_oe && mem_addr == a)) bad_pins++;
            end
            @(negedge clk);
            lat++;
        end
        rd = rdata;
        chk(lat == 2 + (we ? E_WR : E_RD), "R7 done latency", lat, 2 + (we ? E_WR : E_RD));
        if (we) chk(wlow == E_WR && olow == 0 && bad_pins == 0, "R4 write strobe", wlow, E_WR);
        else    chk(olow == E_RD && wlow == 0 && bad_pins == 0, "R3 read strobe", olow, E_RD);
        @(negedge clk);
        chk(!done, "R7 done one clock", int'(done), 0);
    endtask

    initial begin
        logic [7:0] r, held;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hA5 ^ 8'(i);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !done && req_ready,
            "R1 reset pins", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, done, req_ready}, 7'b1011001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_cs_n && !mem_dq_oe, "R1 idle after reset", int'(req_ready), 1);

        // R8: phase counts at a 20 ns clock
        chk(E_RD == 1 && E_WR == 1, "R8 derived counts", E_RD * 16 + E_WR, 17);

        // Read a few untouched words first (R3).
        do_op(1'b0, 13'd0, 8'h00, r);
        chk(r == (8'hA5 ^ 8'd0), "R3 read initial 0", r, 8'hA5);
        do_op(1'b0, 13'd8191, 8'h00, r);
        chk(r == (8'hA5 ^ 8'hFF), "R3 read initial 8191", r, 8'hA5 ^ 8'hFF);

        // Full write sweep then full read sweep (R4, R3).
        for (int a = 0; a < DEPTH; a++) do_op(1'b1, 13'(a), pat(a, 8'h3C), r);
        for (int a = 0; a < DEPTH; a++) begin
            do_op(1'b0, 13'(a), 8'h00, r);
            chk(r == pat(a, 8'h3C), "R4 sweep readback", r, pat(a, 8'h3C));
        end

        // R2: request held while busy must be ignored.
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 13'd100; req_wdata = 8'h11;
        @(negedge clk);
        req_addr = 13'd200; req_wdata = 8'hEE;
        chk(!req_ready, "R2 busy after accept", int'(req_ready), 0);
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        do_op(1'b0, 13'd200, 8'h00, r);
        chk(r == pat(200, 8'h3C), "R2 busy request ignored", r, pat(200, 8'h3C));
        do_op(1'b0, 13'd100, 8'h00, r);
        chk(r == 8'h11, "R2 accepted write landed", r, 8'h11);

        // R7: rdata held across a write and idle time.
        do_op(1'b0, 13'd77, 8'h00, held);
        do_op(1'b1, 13'd78, 8'h5A, r);
        chk(r == held, "R7 rdata held over write", r, held);
        repeat (4) @(negedge clk);
        chk(rdata == held, "R7 rdata held idle", rdata, held);

        // Partial second pattern, including boundaries (R4).
        for (int a = 0; a < 64; a++) do_op(1'b1, 13'(a * 128 + 127), pat(a, 8'hC3), r);
        for (int a = 0; a < 64; a++) begin
            do_op(1'b0, 13'(a * 128 + 127), 8'h00, r);
            chk(r == pat(a, 8'hC3), "R4 second pattern", r, pat(a, 8'hC3));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule